// File: doc/BRIEF.md
# Protected Two-Wire Memory Slave

This block is the serial front end of a 1 KB byte memory. The memory is split into 8 blocks, each of 8 pages of 16 bytes. Two further 16-byte pages sit beside it: a protection page and an identity page. A bus master reaches them through a second device code. The block samples SCL and SDA with its own clock and decodes device and word addresses. It keeps an internal byte pointer that follows different wrap rules for writes and for reads, and it drives SDA low through an output-enable for ACK and read data.

Every data write and every read that opens a transfer is put to an external permission unit. The query carries a flag that selects the extra pages and the address being touched. The unit answers combinationally with read and write grants. A write-protect input refuses all data writes. A power-good input holds the serial logic in reset while it is low, and the stored bytes are kept. After a STOP that ends a write in which bytes were stored, the block stays deaf for a parameterised number of clocks. This stands in for the nonvolatile programming time.

Top module: `prot_eeprom_slave`

## Requirements
- R1: A device byte of the form 1010_1xxR is acknowledged for the main array. Device bytes 1011_1000 (write) and 1011_1001 (read) are acknowledged for the extra pages. Any other device byte gets no ACK.
- R2: For a main write, device bits [2:1] give block bits 2 and 1. In the word address byte, bit 7 gives block bit 0, bits [6:4] give the page and bits [3:0] give the byte. Acknowledged data is stored at that location.
- R3: During a write the pointer advances within the 16-byte page and wraps from byte 15 to byte 0 of the same page.
- R4: A main read ignores the block bits of its device byte and reads from the block latched by the last word address. A sequential read wraps from offset 127 to offset 0 of that block.
- R5: For the extra pages, word addresses 0x00–0x0F select the protection page and 0x10–0x1F select the identity page. A word address with any of bits [7:5] set is not acknowledged.
- R6: Extra-page access is single-byte. A second data byte in the same write is not acknowledged and not stored. A read that continues past the first byte gets the bus released, so the master sees 0xFF.
- R7: While wp_i is high, every data byte is not acknowledged and not stored. Device and word address bytes are still acknowledged, so the pointer can be loaded for a read.
- R8: A data byte for which perm_wr_i is low is not acknowledged and not stored. A read device byte for which perm_rd_i is low is not acknowledged. perm_ext_o and perm_addr_o identify the location queried.
- R9: While pwr_ok_i is low, the serial logic is held in reset and sda_oe_o is released within one clock. The stored bytes are retained.
- R10: After a STOP that ends a write with at least one stored byte, the block acknowledges nothing for WRITE_CYCLES clocks. After that it responds normally.
- R11: Bytes move most significant bit first. sda_oe_o changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pwr_ok_i | input | 1 | Power good; low holds the serial logic in reset |
| wp_i | input | 1 | Write protect; high refuses all data writes |
| scl_i | input | 1 | Bus clock from the master |
| sda_i | input | 1 | Bus data level as seen on the wire |
| sda_oe_o | output | 1 | High pulls SDA low |
| perm_ext_o | output | 1 | Query targets the extra pages |
| perm_addr_o | output | 10 | Queried address (main byte address, or extra-page index in the low 5 bits) |
| perm_rd_i | input | 1 | Read grant for the queried location |
| perm_wr_i | input | 1 | Write grant for the queried location |

## Verification
The bench writes across a page end and reads across a block end. A design that wrapped at the wrong boundary would spill data into the next page or block, or return bytes from elsewhere. A read is issued with different block bits in its device byte than the latched block, and that catches a design that decodes them on reads. On the extra pages, the bench checks the second data byte, an out-of-range word address, and read continuation. Leaking any of these would corrupt the identity page or acknowledge an illegal index. Write protect, denied grants, a power-good drop while data is driven, and an address attempt during the busy window each show up as a wrong ACK, a changed stored byte or a stuck SDA.

// File: rtl/prot_eeprom_pkg.sv
package prot_eeprom_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_RX, S_ACK, S_ACKD, S_TX, S_MACK, S_MNEXT
  } st_e;

  typedef enum logic [1:0] {PH_DEV, PH_WADDR, PH_WDATA} ph_e;

  localparam logic [4:0] MAIN_CODE = 5'b10101;
  localparam logic [6:0] EXT_CODE  = 7'b1011100;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [SYNC_STAGES:0] scl_sr, sda_sr;
  logic scl_prev, sda_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_sr <= '1;
      sda_sr <= '1;
    end else begin
      scl_sr <= {scl_sr[SYNC_STAGES-1:0], scl_i};
      sda_sr <= {sda_sr[SYNC_STAGES-1:0], sda_i};
    end
  end

  assign scl_o      = scl_sr[SYNC_STAGES-1];
  assign sda_o      = sda_sr[SYNC_STAGES-1];
  assign scl_prev   = scl_sr[SYNC_STAGES];
  assign sda_prev   = sda_sr[SYNC_STAGES];
  assign scl_rise_o = scl_o & ~scl_prev;
  assign scl_fall_o = ~scl_o & scl_prev;
  assign start_o    = scl_o & scl_prev & sda_prev & ~sda_o;
  assign stop_o     = scl_o & scl_prev & ~sda_prev & sda_o;
endmodule

// File: rtl/twi_ptr.sv
module twi_ptr #(
  parameter int AW   = 10,
  parameter int PG_W = 4,
  parameter int BL_W = 7,
  parameter int EW   = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          ld_main_i,
  input  logic [AW-1:0] main_val_i,
  input  logic          ld_ext_i,
  input  logic [EW-1:0] ext_val_i,
  input  logic          inc_wr_i,
  input  logic          inc_rd_i,
  output logic [AW-1:0] main_o,
  output logic [EW-1:0] ext_o
);
  logic [PG_W-1:0] pg_nx;
  logic [BL_W-1:0] bl_nx;

  assign pg_nx = main_o[PG_W-1:0] + PG_W'(1);
  assign bl_nx = main_o[BL_W-1:0] + BL_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      main_o <= '0;
      ext_o  <= '0;
    end else if (clr_i) begin
      main_o <= '0;
      ext_o  <= '0;
    end else begin
      if (ld_main_i)     main_o <= main_val_i;
      else if (inc_wr_i) main_o <= {main_o[AW-1:PG_W], pg_nx};
      else if (inc_rd_i) main_o <= {main_o[AW-1:BL_W], bl_nx};
      if (ld_ext_i)      ext_o  <= ext_val_i;
    end
  end
endmodule

// File: rtl/twi_store.sv
module twi_store #(
  parameter int MAIN_BYTES = 1024,
  parameter int EXT_BYTES  = 32,
  parameter int AW         = 10,
  parameter int EW         = 5
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic          ext_i,
  input  logic [AW-1:0] addr_i,
  input  logic [7:0]    wdata_i,
  output logic [7:0]    rdata_o
);
  logic [7:0] main_mem [MAIN_BYTES];
  logic [7:0] ext_mem  [EXT_BYTES];

  // nonvolatile contents: no reset
  always_ff @(posedge clk_i) begin
    if (we_i) begin
      if (ext_i) ext_mem[addr_i[EW-1:0]] <= wdata_i;
      else       main_mem[addr_i]        <= wdata_i;
    end
  end

  assign rdata_o = ext_i ? ext_mem[addr_i[EW-1:0]] : main_mem[addr_i];
endmodule

// File: rtl/prot_eeprom_slave.sv
module prot_eeprom_slave
  import prot_eeprom_pkg::*;
#(
  parameter int BLOCKS       = 8,
  parameter int PAGES        = 8,
  parameter int PAGE_BYTES   = 16,
  parameter int WRITE_CYCLES = 400,
  parameter int SYNC_STAGES  = 2,
  localparam int AW = $clog2(BLOCKS * PAGES * PAGE_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pwr_ok_i,
  input  logic          wp_i,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  output logic          perm_ext_o,
  output logic [AW-1:0] perm_addr_o,
  input  logic          perm_rd_i,
  input  logic          perm_wr_i
);
  localparam int MAIN_BYTES = BLOCKS * PAGES * PAGE_BYTES;
  localparam int EXT_BYTES  = 2 * PAGE_BYTES;
  localparam int PG_W       = $clog2(PAGE_BYTES);
  localparam int BL_W       = $clog2(PAGES * PAGE_BYTES);
  localparam int EW         = $clog2(EXT_BYTES);
  localparam int DEV_AW     = AW - 8;
  localparam int BW         = $clog2(WRITE_CYCLES + 1);

  logic scl_s, sda_s, scl_rise, scl_fall, start_p, stop_p;
  st_e  st;
  ph_e  ph;
  logic [2:0]        bit_cnt;
  logic [7:0]        sh, tx_sh, rx_byte, rd_data, nx_byte;
  logic              rd_mode, ext_mode, ext_done, wrote;
  logic [DEV_AW-1:0] dev_hi;
  logic [BW-1:0]     busy_cnt;
  logic              busy, byte_done, ack_d, dev_main, dev_ext;
  logic              mem_we, ld_main, ld_ext, inc_rd;
  logic [AW-1:0]     main_ptr, mem_addr;
  logic [EW-1:0]     ext_ptr;

  twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start_p), .stop_o(stop_p)
  );

  assign rx_byte   = {sh[6:0], sda_s};
  assign byte_done = (st == S_RX) && scl_rise && (bit_cnt == 3'd7) && !busy;
  assign dev_main  = rx_byte[7:3] == MAIN_CODE;
  assign dev_ext   = rx_byte[7:1] == EXT_CODE;
  assign busy      = busy_cnt != '0;

  // permission query: during the device byte the code being received picks the space
  assign perm_ext_o  = (ph == PH_DEV) ? dev_ext : ext_mode;
  assign perm_addr_o = perm_ext_o ? AW'(ext_ptr) : main_ptr;

  always_comb begin
    ack_d = 1'b0;
    unique case (ph)
      PH_DEV:   if (dev_main || dev_ext) ack_d = rx_byte[0] ? perm_rd_i : 1'b1;
      PH_WADDR: ack_d = ext_mode ? (rx_byte[7:EW] == '0) : 1'b1;
      PH_WDATA: ack_d = !wp_i && perm_wr_i && !(ext_mode && ext_done);
      default:  ack_d = 1'b0;
    endcase
  end

  assign mem_we  = byte_done && (ph == PH_WDATA) && ack_d;
  assign ld_main = byte_done && (ph == PH_WADDR) && !ext_mode;
  assign ld_ext  = byte_done && (ph == PH_WADDR) && ext_mode && ack_d;
  assign inc_rd  = (st == S_MACK) && scl_rise && !ext_mode && !busy;

  twi_ptr #(.AW(AW), .PG_W(PG_W), .BL_W(BL_W), .EW(EW)) u_ptr (
    .clk_i, .rst_ni, .clr_i(!pwr_ok_i),
    .ld_main_i(ld_main), .main_val_i({dev_hi, rx_byte}),
    .ld_ext_i(ld_ext), .ext_val_i(rx_byte[EW-1:0]),
    .inc_wr_i(mem_we && !ext_mode), .inc_rd_i(inc_rd),
    .main_o(main_ptr), .ext_o(ext_ptr)
  );

  assign mem_addr = ext_mode ? AW'(ext_ptr) : main_ptr;

  twi_store #(.MAIN_BYTES(MAIN_BYTES), .EXT_BYTES(EXT_BYTES), .AW(AW), .EW(EW)) u_store (
    .clk_i, .we_i(mem_we), .ext_i(ext_mode), .addr_i(mem_addr),
    .wdata_i(rx_byte), .rdata_o(rd_data)
  );

  assign nx_byte = ext_mode ? 8'hFF : rd_data;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= S_IDLE; ph <= PH_DEV; bit_cnt <= '0; sh <= '0; tx_sh <= '0;
      sda_oe_o <= 1'b0; rd_mode <= 1'b0; ext_mode <= 1'b0; ext_done <= 1'b0;
      wrote <= 1'b0; dev_hi <= '0; busy_cnt <= '0;
    end else if (!pwr_ok_i) begin
      st <= S_IDLE; ph <= PH_DEV; bit_cnt <= '0; sh <= '0; tx_sh <= '0;
      sda_oe_o <= 1'b0; rd_mode <= 1'b0; ext_mode <= 1'b0; ext_done <= 1'b0;
      wrote <= 1'b0; dev_hi <= '0; busy_cnt <= '0;
    end else if (busy) begin
      busy_cnt <= busy_cnt - BW'(1);
      st       <= S_IDLE;
      sda_oe_o <= 1'b0;
    end else if (start_p) begin
      st <= S_RX; ph <= PH_DEV; bit_cnt <= '0; sda_oe_o <= 1'b0;
    end else if (stop_p) begin
      st <= S_IDLE; sda_oe_o <= 1'b0;
      if (wrote) busy_cnt <= BW'(WRITE_CYCLES);
      wrote <= 1'b0;
    end else begin
      unique case (st)
        S_RX: if (scl_rise) begin
          sh      <= rx_byte;
          bit_cnt <= bit_cnt + 3'd1;
          if (bit_cnt == 3'd7) begin
            st <= ack_d ? S_ACK : S_IDLE;
            unique case (ph)
              PH_DEV: begin
                rd_mode  <= rx_byte[0];
                ext_mode <= dev_ext;
                ext_done <= 1'b0;
                if (!rx_byte[0]) dev_hi <= rx_byte[DEV_AW:1];
                ph <= PH_WADDR;
              end
              PH_WADDR: ph <= PH_WDATA;
              default: if (ack_d) begin
                wrote <= 1'b1;
                if (ext_mode) ext_done <= 1'b1;
              end
            endcase
          end
        end
        S_ACK: if (scl_fall) begin
          sda_oe_o <= 1'b1;
          st       <= S_ACKD;
        end
        S_ACKD: if (scl_fall) begin
          bit_cnt <= '0;
          if (rd_mode) begin
            tx_sh    <= rd_data;
            sda_oe_o <= ~rd_data[7];
            st       <= S_TX;
          end else begin
            sda_oe_o <= 1'b0;
            st       <= S_RX;
          end
        end
        S_TX: if (scl_fall) begin
          if (bit_cnt == 3'd7) begin
            sda_oe_o <= 1'b0;
            st       <= S_MACK;
          end else begin
            tx_sh    <= {tx_sh[6:0], 1'b0};
            sda_oe_o <= ~tx_sh[6];
            bit_cnt  <= bit_cnt + 3'd1;
          end
        end
        S_MACK: if (scl_rise) st <= sda_s ? S_IDLE : S_MNEXT;
        S_MNEXT: if (scl_fall) begin
          tx_sh    <= nx_byte;
          sda_oe_o <= ~nx_byte[7];
          bit_cnt  <= '0;
          st       <= S_TX;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/prot_eeprom_chk.sv
module prot_eeprom_chk #(
  parameter int AW   = 10,
  parameter int PG_W = 4,
  parameter int BL_W = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          pwr_ok_i,
  input logic          wp_i,
  input logic          scl_s,
  input logic          sda_oe_o,
  input logic          busy,
  input logic          mem_we,
  input logic          ext_mode,
  input logic          rd_mode,
  input logic [AW-1:0] main_ptr
);
  p_pwr_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_ok_i |=> !sda_oe_o);

  p_busy_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !sda_oe_o);

  p_wp_no_store_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wp_i |-> !mem_we);

  p_oe_scl_low_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_s && $past(scl_s) && pwr_ok_i && $past(pwr_ok_i) |-> $stable(sda_oe_o));

  p_page_wrap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we && !ext_mode && pwr_ok_i |=> main_ptr[AW-1:PG_W] == $past(main_ptr[AW-1:PG_W]));

  p_block_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_mode && $past(rd_mode) && !ext_mode && $past(pwr_ok_i)
      |-> main_ptr[AW-1:BL_W] == $past(main_ptr[AW-1:BL_W]));
endmodule

bind prot_eeprom_slave prot_eeprom_chk #(.AW(AW), .PG_W(PG_W), .BL_W(BL_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pwr_ok_i(pwr_ok_i), .wp_i(wp_i),
  .scl_s(scl_s), .sda_oe_o(sda_oe_o), .busy(busy), .mem_we(mem_we),
  .ext_mode(ext_mode), .rd_mode(rd_mode), .main_ptr(main_ptr)
);

// File: tb/sim_prot_eeprom_slave.sv
module sim_prot_eeprom_slave;
  localparam int Q  = 6;
  localparam int WC = 400;

  logic clk = 1'b0, rst_n = 1'b0, pwr_ok = 1'b1, wp = 1'b0;
  logic scl = 1'b1, sda_m = 1'b1;
  logic sda_oe, perm_ext, perm_rd, perm_wr, sda_line;
  logic [9:0] perm_addr;
  logic [7:0] rd_deny = '0, wr_deny = '0;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;
  assign perm_rd  = perm_ext ? 1'b1 : !rd_deny[perm_addr[9:7]];
  assign perm_wr  = perm_ext ? 1'b1 : !wr_deny[perm_addr[9:7]];

  prot_eeprom_slave #(.WRITE_CYCLES(WC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .pwr_ok_i(pwr_ok), .wp_i(wp),
    .scl_i(scl), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .perm_ext_o(perm_ext), .perm_addr_o(perm_addr),
    .perm_rd_i(perm_rd), .perm_wr_i(perm_wr)
  );

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start;
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b0; wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; wt(Q); scl = 1'b1; wt(Q); sda_m = 1'b1; wt(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q);
    end
    sda_m = 1'b1; wt(Q); scl = 1'b1; wt(Q);
    ack = (sda_line == 1'b0);
    wt(Q); scl = 1'b0; wt(Q);
  endtask

  task automatic recv_byte(input logic more, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(Q); scl = 1'b1; wt(Q); b[i] = sda_line; wt(Q); scl = 1'b0; wt(Q);
    end
    sda_m = ~more; wt(Q); scl = 1'b1; wt(2*Q); scl = 1'b0; wt(Q); sda_m = 1'b1;
  endtask

  // start, device write byte, word address; returns ACK of both
  task automatic addr_phase(input logic [7:0] dev, input logic [7:0] word, output logic ok);
    logic a1, a2;
    bus_start; send_byte(dev, a1); send_byte(word, a2);
    ok = a1 & a2;
  endtask

  task automatic read_one(input logic [7:0] devw, input logic [7:0] word,
                          input logic [7:0] devr, output logic [7:0] b);
    logic ok, a;
    addr_phase(devw, word, ok);
    bus_start; send_byte(devr, a);
    recv_byte(1'b0, b); bus_stop;
  endtask

  task automatic t_reset;
    chk("R9 reset sda released", sda_oe, 0);
  endtask

  task automatic t_decode;
    logic a;
    bus_start; send_byte(8'hA8, a); bus_stop; chk("R1 A8 acked", a, 1);
    bus_start; send_byte(8'hA0, a); bus_stop; chk("R1 A0 not acked", a, 0);
    bus_start; send_byte(8'hBA, a); bus_stop; chk("R1 BA not acked", a, 0);
    bus_start; send_byte(8'hB8, a); bus_stop; chk("R1 B8 acked", a, 1);
  endtask

  task automatic t_write_read;
    logic ok, a; logic [7:0] b;
    addr_phase(8'hAC, 8'hB2, ok); chk("R2 address acked", ok, 1);
    send_byte(8'h11, a); chk("R2 data0 ack", a, 1);
    send_byte(8'h22, a); chk("R2 data1 ack", a, 1);
    send_byte(8'h33, a); bus_stop; wt(WC + 50);
    addr_phase(8'hAC, 8'hB2, ok);
    bus_start; send_byte(8'hA9, a); chk("R4 read dev with other block bits acked", a, 1);
    recv_byte(1'b1, b); chk("R2 R11 byte0", b, 8'h11);
    recv_byte(1'b1, b); chk("R2 byte1", b, 8'h22);
    recv_byte(1'b0, b); chk("R2 byte2", b, 8'h33);
    bus_stop;
  endtask

  task automatic t_page_wrap;
    logic ok, a; logic [7:0] b;
    addr_phase(8'hAA, 8'h1E, ok);
    for (int i = 0; i < 4; i++) send_byte(8'hA0 + 8'(i), a);
    bus_stop; wt(WC + 50);
    addr_phase(8'hAA, 8'h10, ok); bus_start; send_byte(8'hA9, a);
    recv_byte(1'b1, b); chk("R3 page byte0 from wrap", b, 8'hA2);
    recv_byte(1'b0, b); chk("R3 page byte1 from wrap", b, 8'hA3);
    bus_stop;
    read_one(8'hAA, 8'h1F, 8'hA9, b); chk("R3 page byte15", b, 8'hA1);
  endtask

  task automatic t_block_wrap;
    logic ok, a; logic [7:0] b;
    addr_phase(8'hAA, 8'h7F, ok); send_byte(8'h5A, a); bus_stop; wt(WC + 50);
    addr_phase(8'hAA, 8'h00, ok); send_byte(8'hC3, a); bus_stop; wt(WC + 50);
    addr_phase(8'hAA, 8'h7F, ok); bus_start; send_byte(8'hAD, a);
    recv_byte(1'b1, b); chk("R4 block last byte", b, 8'h5A);
    recv_byte(1'b0, b); chk("R4 wrap to block start", b, 8'hC3);
    bus_stop;
  endtask

  task automatic t_busy;
    logic ok, a; logic [7:0] b;
    addr_phase(8'hAA, 8'h00, ok); send_byte(8'h77, a); bus_stop;
    bus_start; send_byte(8'hA8, a); bus_stop; chk("R10 no ack while busy", a, 0);
    wt(WC + 50);
    bus_start; send_byte(8'hA8, a); bus_stop; chk("R10 ack after busy", a, 1);
    read_one(8'hAA, 8'h00, 8'hA9, b); chk("R10 written byte", b, 8'h77);
  endtask

  task automatic t_ext;
    logic ok, a; logic [7:0] b;
    addr_phase(8'hB8, 8'h13, ok); chk("R5 id word acked", ok, 1);
    send_byte(8'h7E, a); chk("R5 id data acked", a, 1);
    send_byte(8'h55, a); chk("R6 second byte not acked", a, 0);
    bus_stop; wt(WC + 50);
    addr_phase(8'hB8, 8'h13, ok); bus_start; send_byte(8'hB9, a);
    chk("R1 B9 acked", a, 1);
    recv_byte(1'b1, b); chk("R6 id byte kept", b, 8'h7E);
    recv_byte(1'b0, b); chk("R6 continued read released", b, 8'hFF);
    bus_stop;
    addr_phase(8'hB8, 8'h20, ok); bus_stop; chk("R5 word 0x20 not acked", ok, 0);
    addr_phase(8'hB8, 8'h05, ok); send_byte(8'h9C, a); bus_stop; wt(WC + 50);
    read_one(8'hB8, 8'h05, 8'hB9, b); chk("R5 protection page byte", b, 8'h9C);
    read_one(8'hB8, 8'h13, 8'hB9, b); chk("R5 id byte separate", b, 8'h7E);
  endtask

  task automatic t_wp;
    logic ok, a; logic [7:0] b;
    wp = 1'b1;
    addr_phase(8'hAC, 8'hB2, ok); chk("R7 address acked under wp", ok, 1);
    send_byte(8'hEE, a); chk("R7 data refused", a, 0);
    bus_stop;
    read_one(8'hAC, 8'hB2, 8'hA9, b); chk("R7 read under wp", b, 8'h11);
    wp = 1'b0;
    read_one(8'hAC, 8'hB2, 8'hA9, b); chk("R7 byte unchanged", b, 8'h11);
  endtask

  task automatic t_perm;
    logic ok, a; logic [7:0] b;
    wr_deny[5] = 1'b1;
    addr_phase(8'hAC, 8'hB2, ok); send_byte(8'hEE, a); bus_stop;
    chk("R8 denied write not acked", a, 0);
    wr_deny = '0; rd_deny[5] = 1'b1;
    addr_phase(8'hAC, 8'hB2, ok); bus_start; send_byte(8'hA9, a); bus_stop;
    chk("R8 denied read not acked", a, 0);
    rd_deny = '0;
    read_one(8'hAC, 8'hB2, 8'hA9, b); chk("R8 byte unchanged", b, 8'h11);
  endtask

  task automatic t_pwr;
    logic ok, a; logic [7:0] b;
    addr_phase(8'hAC, 8'hB2, ok); bus_start; send_byte(8'hA9, a);
    chk("R11 msb 0 driven first", sda_oe, 1);
    pwr_ok = 1'b0; wt(3);
    chk("R9 sda released in reset", sda_oe, 0);
    pwr_ok = 1'b1; wt(2);
    bus_stop;
    read_one(8'hAC, 8'hB2, 8'hA9, b); chk("R9 memory retained", b, 8'h11);
  endtask

  initial begin
    wt(5); rst_n = 1'b1; wt(5);
    t_reset;
    t_decode;
    t_write_read;
    t_page_wrap;
    t_block_wrap;
    t_busy;
    t_ext;
    t_wp;
    t_perm;
    t_pwr;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule